// File: doc/BRIEF.md
# Serial-Loaded Switch Enable Register

This block takes an eight-bit switch-enable word from a three-wire serial link: an active-low frame line, a serial clock and a serial data line. The three serial lines are sampled by a much faster system clock through synchronizers, so every register in the block runs on that one clock. While the frame line is low, each falling serial-clock edge pushes one data bit into a shift register, most significant bit first. Frames may be shorter or longer than eight bits; the register always holds the eight most recent bits.

When the frame line returns high, the whole register is copied into the latched enable vector in a single cycle, so all switches change together. Between frames, activity on the clock and data lines is ignored. A chain output presents the bit leaving the top of the register on each rising serial-clock edge. This lets several blocks share one frame line in a daisy chain. That output is modelled as an open-drain pull-low enable. An active-low clear input and the system reset both zero the register, the enables and the chain bit.

Top module: `serial_switch_ctrl`

## Requirements
- R1: After system reset, `sw_en` is all zero and `chain_pull_low` is 1 (chain bit at 0). Both stay so until a frame completes.
- R2: During a frame, each falling `ser_clk` edge shifts `ser_din` into bit 0 and moves the older bits up. After an eight-bit frame, the first bit sent is in `sw_en[7]` (switch 8) and the last is in `sw_en[0]` (switch 1). A 1 turns a switch on.
- R3: While `frame_n` is high, toggling `ser_clk` and `ser_din` changes neither the shift register nor `chain_pull_low`.
- R4: A frame of fewer than eight bits shifts the older contents up by the number of bits sent and keeps them.
- R5: A frame of more than eight bits leaves only the last eight bits sent.
- R6: `sw_en` changes only on a rising `frame_n` edge, with all bits at once. It still holds the old value two system clocks after the edge is first sampled, and holds the new value from the third.
- R7: Inside a frame, each rising `ser_clk` edge sets `chain_pull_low` to the inverse of shift-register bit 7. The chain bit stream is therefore the data stream delayed by eight bits.
- R8: A frame with no clock edges latches the unchanged register contents into `sw_en`.
- R9: Driving `clr_n` low zeroes `sw_en`, the shift register and the chain bit at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous system (power-up) reset |
| clr_n | input | 1 | Active-low asynchronous clear of register, enables and chain bit |
| frame_n | input | 1 | Active-low frame line, asynchronous to clk |
| ser_clk | input | 1 | Serial clock, asynchronous to clk |
| ser_din | input | 1 | Serial data, sampled at falling ser_clk |
| sw_en | output | WORD_W | Latched switch enables, 1 = switch on |
| chain_pull_low | output | 1 | Open-drain chain output: 1 = pull low, 0 = released (high) |

## Verification
The bench builds the block with its defaults: an eight-bit word and two synchronizer stages. It runs the serial clock at one eighth of the system clock. With these settings, the bench can follow a bit through the synchronizer latency, a full word through the register and out of the chain pin, and both short and over-length frames within one short run. A behavioural model fed the same sampled inputs with a two-cycle delay is compared on every clock, alongside directed checks at the frame boundaries and around an asynchronous clear.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } line_evt_t;

  function automatic line_evt_t sense_line(input logic prev, input logic cur);
    line_evt_t e;
    e.level = cur;
    e.rise  = cur & ~prev;
    e.fall  = prev & ~cur;
    return e;
  endfunction

endpackage

// File: rtl/ssc_line_sync.sv
module ssc_line_sync
  import ssc_pkg::*;
#(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      raw,
  output line_evt_t evt
);
  logic [STAGES-1:0] stg;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= {STAGES{IDLE_LV}};
      prev <= IDLE_LV;
    end else begin
      stg  <= {stg[STAGES-2:0], raw};
      prev <= stg[STAGES-1];
    end
  end

  assign evt = sense_line(prev, stg[STAGES-1]);
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              shift_en,
  input  logic              drive_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              chain_bit
);
  function automatic logic [WORD_W-1:0] push_lsb(input logic [WORD_W-1:0] w, input logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      word      <= '0;
      chain_bit <= 1'b0;
    end else begin
      if (shift_en) word <= push_lsb(word, bit_in);
      if (drive_en) chain_bit <= word[WORD_W-1];
    end
  end
endmodule

// File: rtl/ssc_latch.sv
module ssc_latch #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/serial_switch_ctrl.sv
module serial_switch_ctrl
  import ssc_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [WORD_W-1:0] sw_en,
  output logic              chain_pull_low
);
  localparam int          NLINES  = 3;
  localparam int          L_CLK   = 0;
  localparam int          L_DIN   = 1;
  localparam int          L_FRAME = 2;
  localparam logic [2:0]  IDLE_LV = 3'b100;

  logic [NLINES-1:0] raw_lines;
  line_evt_t         evt [NLINES];

  assign raw_lines = {frame_n, ser_din, ser_clk};

  for (genvar i = 0; i < NLINES; i++) begin : g_sync
    ssc_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(IDLE_LV[i])) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lines[i]),
      .evt   (evt[i])
    );
  end

  // Named internal events, observed by the bound checker.
  logic              in_frame;
  logic              shift_evt;
  logic              drive_evt;
  logic              latch_evt;
  logic              arst_n;
  logic [WORD_W-1:0] shift_word;
  logic              chain_bit;

  assign in_frame  = ~evt[L_FRAME].level;
  assign shift_evt = in_frame & evt[L_CLK].fall;
  assign drive_evt = in_frame & evt[L_CLK].rise;
  assign latch_evt = evt[L_FRAME].rise;
  assign arst_n    = rst_n & clr_n;

  ssc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .arst_n    (arst_n),
    .shift_en  (shift_evt),
    .drive_en  (drive_evt),
    .bit_in    (evt[L_DIN].level),
    .word      (shift_word),
    .chain_bit (chain_bit)
  );

  ssc_latch #(.WORD_W(WORD_W)) u_latch (
    .clk    (clk),
    .arst_n (arst_n),
    .load   (latch_evt),
    .d      (shift_word),
    .q      (sw_en)
  );

  assign chain_pull_low = ~chain_bit;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              drive_evt,
  input logic              latch_evt,
  input logic [WORD_W-1:0] shift_word,
  input logic [WORD_W-1:0] sw_en,
  input logic              chain_pull_low
);
  AST_HOLD_BETWEEN_FRAMES: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !latch_evt |=> $stable(sw_en)); // R6

  AST_LATCH_COPIES_WORD: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    latch_evt |=> sw_en == $past(shift_word)); // R6

  AST_CHAIN_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    drive_evt |=> chain_pull_low == !$past(shift_word[WORD_W-1])); // R7

  AST_CHAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !drive_evt |=> $stable(chain_pull_low)); // R3

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (sw_en == '0 && chain_pull_low)); // R9
endmodule

bind serial_switch_ctrl ssc_checker #(.WORD_W(WORD_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .clr_n          (clr_n),
  .drive_evt      (drive_evt),
  .latch_evt      (latch_evt),
  .shift_word     (shift_word),
  .sw_en          (sw_en),
  .chain_pull_low (chain_pull_low)
);

// File: tb/sim_serial_switch_ctrl.sv
module sim_serial_switch_ctrl;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, clr_n = 1'b1, frame_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic [W-1:0] sw_en;
  logic         chain_pull_low;

  serial_switch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_n(frame_n),
    .ser_clk(ser_clk), .ser_din(ser_din), .sw_en(sw_en), .chain_pull_low(chain_pull_low)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_reg = '0;
  logic [W-1:0] exp_sw  = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural model: acts on inputs seen two samples earlier.
  int h_clk[3], h_din[3], h_fs[3];
  int m_reg = 0, m_sw = 0, m_out = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin h_clk[i] = 0; h_din[i] = 0; h_fs[i] = 1; end
      m_reg = 0; m_sw = 0; m_out = 0;
    end else begin
      if (!clr_n) begin
        m_reg = 0; m_sw = 0; m_out = 0;
      end else begin
        if (h_fs[1] == 0 && h_clk[2] == 1 && h_clk[1] == 0) m_reg = (m_reg * 2 + h_din[1]) % 256;
        else if (h_fs[1] == 0 && h_clk[2] == 0 && h_clk[1] == 1) m_out = m_reg / 128;
        if (h_fs[1] == 1 && h_fs[2] == 0) m_sw = m_reg;
      end
      h_clk[2] = h_clk[1]; h_clk[1] = h_clk[0]; h_clk[0] = int'(ser_clk);
      h_din[2] = h_din[1]; h_din[1] = h_din[0]; h_din[0] = int'(ser_din);
      h_fs[2]  = h_fs[1];  h_fs[1]  = h_fs[0];  h_fs[0]  = int'(frame_n);
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      check("R6 model sw_en", 32'(sw_en), clr_n ? m_sw : 0);
      check("R7 model chain", 32'(chain_pull_low), (clr_n && m_out == 1) ? 0 : 1);
    end
  end

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] bits, input int n, input string req);
    @(negedge clk) frame_n = 1'b0;
    wait_clks(4);
    for (int k = n - 1; k >= 0; k--) begin
      ser_din = bits[k];
      ser_clk = 1'b1;
      wait_clks(4);
      check("R7 chain bit", 32'(chain_pull_low), exp_reg[W-1] ? 0 : 1);
      ser_clk = 1'b0;
      exp_reg = {exp_reg[W-2:0], bits[k]};
      wait_clks(4);
    end
    wait_clks(4);
    check("R6 unchanged mid-frame", 32'(sw_en), 32'(exp_sw));
    frame_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R6 old value two clocks after edge", 32'(sw_en), 32'(exp_sw));
    @(posedge clk); #1;
    check(req, 32'(sw_en), 32'(exp_reg));
    exp_sw = exp_reg;
    wait_clks(4);
  endtask

  initial begin
    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(3);
    check("R1 reset sw_en", 32'(sw_en), 0);
    check("R1 reset chain", 32'(chain_pull_low), 1);

    frame(32'hA5, 8, "R2 msb-first word");
    check("R2 switch8 bit", 32'(sw_en[7]), 1);
    frame(32'h01, 8, "R2 switch1 only");

    begin
      logic pl_before;
      pl_before = chain_pull_low;
      for (int k = 0; k < 10; k++) begin
        ser_din = k[0]; ser_clk = 1'b1; wait_clks(4);
        ser_clk = 1'b0; wait_clks(4);
      end
      check("R3 chain unchanged outside frame", 32'(chain_pull_low), 32'(pl_before));
      check("R3 enables unchanged outside frame", 32'(sw_en), 32'(exp_sw));
    end
    frame(32'h0, 0, "R8 empty frame relatch (R3 register untouched)");

    frame(32'b110, 3, "R4 short frame");
    frame(32'h5F3, 11, "R5 long frame");
    frame(32'hC396, 16, "R7 daisy word through");

    @(negedge clk) clr_n = 1'b0;
    #1;
    check("R9 async clear sw_en", 32'(sw_en), 0);
    check("R9 async clear chain", 32'(chain_pull_low), 1);
    wait_clks(3);
    clr_n = 1'b1;
    exp_reg = '0; exp_sw = '0;
    frame(32'h0, 0, "R9 register zero after clear");
    frame(32'hFF, 8, "R2 all switches on");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule